// File: doc/BRIEF.md
# Ternary and Binary CAM Search Core

This block is a small synchronous content-addressable memory whose entries are 64-bit words split into a low and a high 32-bit half. One word can be searched in two ways. As a ternary entry, each of the 32 key bit positions is encoded by the pair of bits at the same position in the two halves. This allows prefix-style lookups such as routing on address prefixes. As a binary entry, the whole 64-bit word must equal a 64-bit comparand, which suits exact-match keys such as hardware station addresses.

A host drives one command per clock through a 4-bit opcode, a 3-bit mask selector, a segment select and a 32-bit data half-word. Seven mask registers can be loaded. Each one, when selected, protects bits during writes and removes bits from a compare. New entries always go to the lowest-numbered empty location. The core reports that location and a full flag. Each compare registers a match flag, a multi-match flag and the lowest matching address. Later commands can copy the winning word into the comparand or release its location.

Top module: `tbcam_core`

## Requirements
- R1: While reset is asserted, and after it is released, every location is empty. The match flag, multi-match flag, match address, read-back word, comparand and all mask registers are zero, `fullFlag` is 0 and `nextFree` is 0.
- R2: Opcode 1 writes the comparand half chosen by `segHi` (0 = bits 31..0, 1 = bits 63..32) from `dataIn`. Bits that are 1 in the same half of the selected mask keep their old value. Opcode 8 puts the chosen comparand half on `rdData` one clock later. `rdData` holds its value at all other times.
- R3: Opcode 2 loads `dataIn` into the `segHi`-selected half of mask register `maskSel` (1..7). With `maskSel` = 0 the command changes nothing, and selector 0 always acts as an all-zero mask.
- R4: Opcode 4 (ternary store) takes the value A = `dataIn` and the care mask M = the inverse of the low half of the selected mask. It stores A & M into bits 31..0 and ~A & M into bits 63..32 at `nextFree`, and marks that location valid.
- R5: Opcode 3 writes `dataIn` into the `segHi`-selected half of the word at `nextFree`. Bits set in the same half of the selected mask keep their old value. Only a high-half write marks the location valid, so a low-half write leaves `nextFree` unchanged.
- R6: `nextFree` is the lowest empty location, or 0 when all are occupied. `fullFlag` is 1 exactly when every location is valid and changes on the clock edge that ends a store. Stores of opcode 3 or 4 issued while full change nothing.
- R7: Opcode 5 is a ternary compare of the key `dataIn`. A valid word hits when, at every bit i that is 0 in the low half of the selected mask, either key bit i is 1 and stored bit 32+i is 0, or key bit i is 0 and stored bit i is 0.
- R8: Opcode 6 is a binary compare. A valid word hits when it equals the 64-bit comparand at every bit that is 0 in the selected mask.
- R9: After a compare, `matchFlag` shows whether any valid word hit. `matchAddr` is the lowest hitting address, or 0 when there is no hit. `multiFlag` is 1 when two or more valid words hit. Empty locations never hit.
- R10: `matchFlag`, `multiFlag` and `matchAddr` change only on a compare command.
- R11: Opcode 7 copies the word at `matchAddr` into the comparand when `matchFlag` is 1, and does nothing otherwise.
- R12: Opcode 9 marks the location at `matchAddr` empty when `matchFlag` is 1, and does nothing otherwise. Opcode 0 and opcodes 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdOp | input | 4 | Command opcode |
| maskSel | input | 3 | Mask register selector, 0 = no mask |
| segHi | input | 1 | Half select: 0 = bits 31..0, 1 = bits 63..32 |
| dataIn | input | HALF_W | Data half-word, ternary value or ternary key |
| rdData | output | HALF_W | Comparand half read back |
| matchFlag | output | 1 | Last compare found a hit |
| multiFlag | output | 1 | Last compare found two or more hits |
| matchAddr | output | clog2(DEPTH) | Lowest hitting address of the last compare |
| fullFlag | output | 1 | All locations valid |
| nextFree | output | clog2(DEPTH) | Lowest empty location |

## Verification
The bench builds the core with DEPTH = 8 and HALF_W = 32. With eight locations it can fill the array completely, reach the full condition, release a location and reuse it in a few dozen commands. That leaves room to sweep every value of the low key byte against a mix of exact, 24-bit and 16-bit prefix entries, both with no compare mask and with a mask that hides that byte. Each sweep point is checked against a bench model for the hit, multi-hit and priority outcome.

// File: rtl/tbcam_pkg.sv
package tbcam_pkg;

  localparam int MASK_SEL_W = 3;
  localparam int NUM_MASKS  = (1 << MASK_SEL_W) - 1;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_WR_CMP   = 4'd1,
    OP_WR_MASK  = 4'd2,
    OP_WR_HALF  = 4'd3,
    OP_WR_TERN  = 4'd4,
    OP_CMP_TERN = 4'd5,
    OP_CMP_BIN  = 4'd6,
    OP_MOVE     = 4'd7,
    OP_RD_CMP   = 4'd8,
    OP_FREE     = 4'd9
  } camOp_e;

  // strobes handed from the decoder to the datapath
  typedef struct packed {
    logic                  wrCmp;
    logic                  wrMask;
    logic                  wrHalf;
    logic                  wrTern;
    logic                  cmpTern;
    logic                  cmpBin;
    logic                  moveHit;
    logic                  rdCmp;
    logic                  freeHit;
    logic                  hiSeg;
    logic [MASK_SEL_W-1:0] maskIdx;
  } camStrobe_t;

endpackage

// File: rtl/tbcam_prio.sv
// Lowest-index-wins encoder over a request vector.
module tbcam_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/tbcam_ctrl.sv
// Command decoder: turns the opcode into datapath strobes, guarding
// stores against a full array and hit-based commands against no hit.
module tbcam_ctrl
  import tbcam_pkg::*;
(
  input  logic                  cmdValid,
  input  logic [3:0]            cmdOp,
  input  logic [MASK_SEL_W-1:0] maskSel,
  input  logic                  segHi,
  input  logic                  fullFlag,
  input  logic                  matchFlag,
  output camStrobe_t            strobe
);

  always_comb begin
    strobe         = '0;
    strobe.hiSeg   = segHi;
    strobe.maskIdx = maskSel;
    if (cmdValid) begin
      case (cmdOp)
        OP_WR_CMP:   strobe.wrCmp   = 1'b1;
        OP_WR_MASK:  strobe.wrMask  = (maskSel != '0);
        OP_WR_HALF:  strobe.wrHalf  = !fullFlag;
        OP_WR_TERN:  strobe.wrTern  = !fullFlag;
        OP_CMP_TERN: strobe.cmpTern = 1'b1;
        OP_CMP_BIN:  strobe.cmpBin  = 1'b1;
        OP_MOVE:     strobe.moveHit = matchFlag;
        OP_RD_CMP:   strobe.rdCmp   = 1'b1;
        OP_FREE:     strobe.freeHit = matchFlag;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tbcam_dp.sv
// Storage, comparand, masks, parallel compare and result registers.
module tbcam_dp
  import tbcam_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int HALF_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  camStrobe_t        strobe,
  input  logic [HALF_W-1:0] dataIn,
  output logic [HALF_W-1:0] rdData,
  output logic              matchFlag,
  output logic              multiFlag,
  output logic [AW-1:0]     matchAddr,
  output logic              fullFlag,
  output logic [AW-1:0]     nextFree
);

  logic [HALF_W-1:0] wordLo [DEPTH];
  logic [HALF_W-1:0] wordHi [DEPTH];
  logic [DEPTH-1:0]  valid;
  logic [HALF_W-1:0] cmpLo, cmpHi;
  // index 0 is never written and stays zero: selector 0 means no mask
  logic [HALF_W-1:0] maskLo [NUM_MASKS+1];
  logic [HALF_W-1:0] maskHi [NUM_MASKS+1];

  logic [HALF_W-1:0] selLo, selHi, segMask, careBits;
  logic [DEPTH-1:0]  ternMiss, binMiss, hitVec;
  logic [AW-1:0]     hitIdx;
  logic              hitAny, hitMulti, freeAny;

  function automatic logic [HALF_W-1:0] keepMasked(
    input logic [HALF_W-1:0] oldV,
    input logic [HALF_W-1:0] newV,
    input logic [HALF_W-1:0] keep
  );
    return (oldV & keep) | (newV & ~keep);
  endfunction

  assign selLo    = maskLo[strobe.maskIdx];
  assign selHi    = maskHi[strobe.maskIdx];
  assign segMask  = strobe.hiSeg ? selHi : selLo;
  assign careBits = ~selLo;

  // one comparator pair per location
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign ternMiss[g] = |((( dataIn & wordHi[g]) | (~dataIn & wordLo[g])) & careBits);
    assign binMiss[g]  = |((wordLo[g] ^ cmpLo) & ~selLo) | |((wordHi[g] ^ cmpHi) & ~selHi);
    assign hitVec[g]   = valid[g] & (strobe.cmpBin ? ~binMiss[g] : ~ternMiss[g]);
  end

  tbcam_prio #(.N(DEPTH), .IW(AW)) u_hitPrio (
    .req (hitVec),
    .idx (hitIdx),
    .any (hitAny)
  );

  tbcam_prio #(.N(DEPTH), .IW(AW)) u_freePrio (
    .req (~valid),
    .idx (nextFree),
    .any (freeAny)
  );

  assign hitMulti = |(hitVec & (hitVec - DEPTH'(1)));
  assign fullFlag = ~freeAny;

  // array contents: not reset, only validity is
  always_ff @(posedge clk) begin
    if (strobe.wrTern) begin
      wordLo[nextFree] <= dataIn & careBits;
      wordHi[nextFree] <= ~dataIn & careBits;
    end else if (strobe.wrHalf) begin
      if (strobe.hiSeg) wordHi[nextFree] <= keepMasked(wordHi[nextFree], dataIn, segMask);
      else              wordLo[nextFree] <= keepMasked(wordLo[nextFree], dataIn, segMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid     <= '0;
      cmpLo     <= '0;
      cmpHi     <= '0;
      rdData    <= '0;
      matchFlag <= 1'b0;
      multiFlag <= 1'b0;
      matchAddr <= '0;
      for (int m = 0; m <= NUM_MASKS; m++) begin
        maskLo[m] <= '0;
        maskHi[m] <= '0;
      end
    end else begin
      if (strobe.wrTern || (strobe.wrHalf && strobe.hiSeg)) valid[nextFree] <= 1'b1;
      if (strobe.freeHit) valid[matchAddr] <= 1'b0;

      if (strobe.wrCmp) begin
        if (strobe.hiSeg) cmpHi <= keepMasked(cmpHi, dataIn, segMask);
        else              cmpLo <= keepMasked(cmpLo, dataIn, segMask);
      end else if (strobe.moveHit) begin
        cmpLo <= wordLo[matchAddr];
        cmpHi <= wordHi[matchAddr];
      end

      if (strobe.wrMask) begin
        if (strobe.hiSeg) maskHi[strobe.maskIdx] <= dataIn;
        else              maskLo[strobe.maskIdx] <= dataIn;
      end

      if (strobe.rdCmp) rdData <= strobe.hiSeg ? cmpHi : cmpLo;

      if (strobe.cmpTern || strobe.cmpBin) begin
        matchFlag <= hitAny;
        multiFlag <= hitMulti;
        matchAddr <= hitIdx;
      end
    end
  end

endmodule

// File: rtl/tbcam_core.sv
module tbcam_core
  import tbcam_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int HALF_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [3:0]            cmdOp,
  input  logic [MASK_SEL_W-1:0] maskSel,
  input  logic                  segHi,
  input  logic [HALF_W-1:0]     dataIn,
  output logic [HALF_W-1:0]     rdData,
  output logic                  matchFlag,
  output logic                  multiFlag,
  output logic [AW-1:0]         matchAddr,
  output logic                  fullFlag,
  output logic [AW-1:0]         nextFree
);

  camStrobe_t strobe;

  tbcam_ctrl u_ctrl (
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .maskSel   (maskSel),
    .segHi     (segHi),
    .fullFlag  (fullFlag),
    .matchFlag (matchFlag),
    .strobe    (strobe)
  );

  tbcam_dp #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .rdData    (rdData),
    .matchFlag (matchFlag),
    .multiFlag (multiFlag),
    .matchAddr (matchAddr),
    .fullFlag  (fullFlag),
    .nextFree  (nextFree)
  );

endmodule

// File: rtl/tbcam_chk.sv
module tbcam_chk
  import tbcam_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int HALF_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cmdValid,
  input logic [3:0]            cmdOp,
  input logic [MASK_SEL_W-1:0] maskSel,
  input logic                  segHi,
  input logic [HALF_W-1:0]     dataIn,
  input logic [HALF_W-1:0]     rdData,
  input logic                  matchFlag,
  input logic                  multiFlag,
  input logic [AW-1:0]         matchAddr,
  input logic                  fullFlag,
  input logic [AW-1:0]         nextFree
);

  logic isCompare, isRead, isStore;
  assign isCompare = cmdValid && (cmdOp == OP_CMP_TERN || cmdOp == OP_CMP_BIN);
  assign isRead    = cmdValid && (cmdOp == OP_RD_CMP);
  assign isStore   = cmdValid && (cmdOp == OP_WR_TERN || (cmdOp == OP_WR_HALF && segHi));

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_state_r1: assert (!matchFlag && !multiFlag && !fullFlag && nextFree == '0 && rdData == '0)
        else $error("reset state wrong");
    end
  end

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> $stable(rdData));

  p_full_from_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> $past(isStore));

  p_multi_needs_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    multiFlag |-> matchFlag);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !isCompare |=> ($stable(matchFlag) && $stable(multiFlag) && $stable(matchAddr)));

  p_free_opens_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_FREE && matchFlag) |=> !fullFlag);

  // unused here but part of the observed port set
  logic unusedBits;
  assign unusedBits = ^{maskSel, dataIn};

endmodule

bind tbcam_core tbcam_chk #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/tbcam_core_tb.sv
`timescale 1ns/1ps
module tbcam_core_tb;
  import tbcam_pkg::*;

  localparam int DEPTH = 8;
  localparam int HW    = 32;
  localparam int AW    = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [3:0]    cmdOp = '0;
  logic [2:0]    maskSel = '0;
  logic          segHi = 1'b0;
  logic [HW-1:0] dataIn = '0;
  logic [HW-1:0] rdData;
  logic          matchFlag, multiFlag, fullFlag;
  logic [AW-1:0] matchAddr, nextFree;

  tbcam_core #(.DEPTH(DEPTH), .HALF_W(HW)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .maskSel(maskSel), .segHi(segHi), .dataIn(dataIn), .rdData(rdData),
    .matchFlag(matchFlag), .multiFlag(multiFlag), .matchAddr(matchAddr),
    .fullFlag(fullFlag), .nextFree(nextFree)
  );

  always #2 clk = ~clk;

  // bench model
  logic [31:0] mLo [DEPTH];
  logic [31:0] mHi [DEPTH];
  bit          mV  [DEPTH];
  logic [31:0] kLo [8];
  logic [31:0] kHi [8];
  logic [31:0] cLo = '0, cHi = '0;
  bit          eFlag = 0, eMulti = 0;
  logic [2:0]  eAddr = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mFull();
    for (int i = 0; i < DEPTH; i++) if (!mV[i]) return 0;
    return 1;
  endfunction

  function automatic logic [2:0] mNext();
    for (int i = 0; i < DEPTH; i++) if (!mV[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic issue(input camOp_e op, input logic [2:0] sel, input bit seg, input logic [31:0] d);
    cmdOp = op; maskSel = sel; segHi = seg; dataIn = d; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic checkFree(input string tag);
    check(tag, {63'd0, fullFlag}, {63'd0, mFull()});
    check(tag, {61'd0, nextFree}, {61'd0, mNext()});
  endtask

  task automatic wrMask(input logic [2:0] sel, input bit seg, input logic [31:0] d);
    issue(OP_WR_MASK, sel, seg, d);
    if (sel != 0) begin
      if (seg) kHi[sel] = d; else kLo[sel] = d;
    end
  endtask

  task automatic wrCmp(input logic [2:0] sel, input bit seg, input logic [31:0] d);
    issue(OP_WR_CMP, sel, seg, d);
    if (seg) cHi = (cHi & kHi[sel]) | (d & ~kHi[sel]);
    else     cLo = (cLo & kLo[sel]) | (d & ~kLo[sel]);
  endtask

  task automatic readCmp(input bit seg, input string tag);
    issue(OP_RD_CMP, 3'd0, seg, 32'h0);
    check(tag, {32'd0, rdData}, {32'd0, seg ? cHi : cLo});
  endtask

  task automatic wrTern(input logic [2:0] sel, input logic [31:0] a);
    logic [2:0] p;
    p = mNext();
    issue(OP_WR_TERN, sel, 1'b0, a);
    if (!mFull()) begin
      mLo[p] = a & ~kLo[sel];
      mHi[p] = ~a & ~kLo[sel];
      mV[p]  = 1;
    end
    checkFree("R4/R6 ternary store");
  endtask

  task automatic wrHalf(input bit seg, input logic [31:0] d);
    logic [2:0] p;
    p = mNext();
    issue(OP_WR_HALF, 3'd0, seg, d);
    if (!mFull()) begin
      if (seg) begin mHi[p] = d; mV[p] = 1; end
      else mLo[p] = d;
    end
    checkFree("R5/R6 half store");
  endtask

  task automatic modelCompare(input bit bin, input logic [2:0] sel, input logic [31:0] key);
    int n;
    bit h;
    n = 0; eFlag = 0; eAddr = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (bin) h = mV[i] && (((mLo[i] ^ cLo) & ~kLo[sel]) == 0) && (((mHi[i] ^ cHi) & ~kHi[sel]) == 0);
      else     h = mV[i] && ((((key & mHi[i]) | (~key & mLo[i])) & ~kLo[sel]) == 0);
      if (h) begin n++; eFlag = 1; eAddr = 3'(i); end
    end
    eMulti = (n >= 2);
  endtask

  task automatic checkResult(input string tag);
    check({tag, " R9 flag"},  {63'd0, matchFlag}, {63'd0, eFlag});
    check({tag, " R9 multi"}, {63'd0, multiFlag}, {63'd0, eMulti});
    check({tag, " R9 addr"},  {61'd0, matchAddr}, {61'd0, eAddr});
  endtask

  task automatic cmpTern(input logic [2:0] sel, input logic [31:0] key);
    issue(OP_CMP_TERN, sel, 1'b0, key);
    modelCompare(1'b0, sel, key);
    checkResult("R7 ternary");
  endtask

  task automatic cmpBin(input logic [2:0] sel);
    issue(OP_CMP_BIN, sel, 1'b0, 32'h0);
    modelCompare(1'b1, sel, 32'h0);
    checkResult("R8 binary");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mLo[i] = '0; mHi[i] = '0; mV[i] = 0; end
    for (int i = 0; i < 8; i++) begin kLo[i] = '0; kHi[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 full in reset", {63'd0, fullFlag}, 64'd0);
    check("R1 match in reset", {62'd0, matchFlag, multiFlag}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 nextFree", {61'd0, nextFree}, 64'd0);
    check("R1 rdData", {32'd0, rdData}, 64'd0);
    readCmp(1'b0, "R1 comparand low");
    readCmp(1'b1, "R1 comparand high");
    cmpTern(3'd0, 32'h0);   // no valid entries: R1 no hit

    // R3: masks; selector 0 write ignored
    wrMask(3'd0, 1'b0, 32'hFFFF_FFFF);
    wrMask(3'd1, 1'b0, 32'h0000_00FF);
    wrMask(3'd2, 1'b0, 32'h0000_FFFF);
    wrMask(3'd3, 1'b1, 32'hFFFF_0000);
    wrCmp(3'd0, 1'b0, 32'hFFFF_FFFF);
    readCmp(1'b0, "R3 selector 0 is no mask");
    // R2: masked comparand writes
    wrCmp(3'd1, 1'b0, 32'h1234_5600);
    readCmp(1'b0, "R2 masked low write");
    wrCmp(3'd3, 1'b1, 32'hABCD_EF01);
    readCmp(1'b1, "R2 masked high write");
    readCmp(1'b0, "R2 low half untouched");

    // R4: ternary entries, longest prefix placed first
    wrTern(3'd0, 32'hC0A8_0105);
    wrTern(3'd1, 32'hC0A8_0100);
    wrTern(3'd2, 32'hC0A8_0000);
    wrTern(3'd1, 32'h0A00_0000);
    wrTern(3'd2, 32'hC0A9_0000);
    wrTern(3'd0, 32'hFFFF_FFFF);

    // R7/R9: sweep low key byte
    for (int k = 0; k < 256; k++) cmpTern(3'd0, 32'hC0A8_0100 | 32'(k));
    for (int k = 0; k < 256; k++) cmpTern(3'd0, 32'hC0A8_0200 | 32'(k));
    for (int k = 0; k < 256; k += 17) cmpTern(3'd1, 32'hC0A8_0100 | 32'(k));
    cmpTern(3'd2, 32'hC0A9_7777);
    cmpTern(3'd0, 32'hFFFF_FFFF);

    // R5/R6: half stores fill the array
    wrHalf(1'b0, 32'h1111_2222);
    wrHalf(1'b1, 32'h3333_4444);
    wrHalf(1'b0, 32'h1111_2222);
    check("R6 not yet full", {63'd0, fullFlag}, 64'd0);
    wrHalf(1'b1, 32'h3333_4444);
    check("R6 full", {63'd0, fullFlag}, 64'd1);
    wrTern(3'd0, 32'h5555_5555);   // R6 ignored while full
    wrHalf(1'b1, 32'h7777_7777);   // R6 ignored while full

    // R8: binary compare
    wrCmp(3'd0, 1'b0, 32'h1111_2222);
    wrCmp(3'd0, 1'b1, 32'h3333_4444);
    cmpBin(3'd0);
    check("R9 duplicate words", {62'd0, matchFlag, multiFlag}, 64'd3);
    wrCmp(3'd0, 1'b1, 32'hAAAA_4444);
    cmpBin(3'd0);
    cmpBin(3'd3);
    // R10: results hold across other commands
    issue(OP_NOP, 3'd0, 1'b0, 32'h0);
    wrCmp(3'd0, 1'b0, 32'h0);
    issue(camOp_e'(4'd12), 3'd0, 1'b0, 32'h0);
    checkResult("R10 hold");
    check("R12 unused opcode", {63'd0, fullFlag}, 64'd1);

    // R11: move winning word to the comparand
    cmpTern(3'd0, 32'hC0A8_0107);
    issue(OP_MOVE, 3'd0, 1'b0, 32'h0);
    if (eFlag) begin cLo = mLo[eAddr]; cHi = mHi[eAddr]; end
    readCmp(1'b0, "R11 moved low");
    readCmp(1'b1, "R11 moved high");
    cmpTern(3'd0, 32'h5555_5555);
    issue(OP_MOVE, 3'd0, 1'b0, 32'h0);
    readCmp(1'b0, "R11 no hit keeps low");
    readCmp(1'b1, "R11 no hit keeps high");

    // R12: release and reuse
    issue(OP_FREE, 3'd0, 1'b0, 32'h0);
    checkFree("R12 free without hit");
    cmpTern(3'd0, 32'hC0A8_0105);
    issue(OP_FREE, 3'd0, 1'b0, 32'h0);
    if (eFlag) mV[eAddr] = 0;
    checkFree("R12 free releases slot");
    cmpTern(3'd0, 32'hC0A8_0105);
    wrTern(3'd0, 32'h0102_0304);
    cmpTern(3'd0, 32'h0102_0304);
    cmpTern(3'd0, 32'hC0A8_0105);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog all requirements actual=hung expected=finished");
        end
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule